// File: doc/BRIEF.md
# DMA Buffer-to-Burst Segmenter

This block takes one DMA buffer (a start address, a length counted in transfer-width beats, and a flag that says whether the far side is memory or a peripheral) and turns it into a stream of bus commands for an AHB-style master. Each command carries an address, a beat count and a flag that marks it as a single access or an incrementing burst. The master accepts a command with a ready/valid handshake. The block does not move data, drive bus protocol signals or fetch descriptors.

For a memory buffer, commands are produced back to back. Each one is the largest incrementing burst the remaining length allows, up to a cap of 16 beats, and a final lone beat becomes a single access. For a peripheral buffer, the block waits for a request from the peripheral before each transaction. A single request yields one single access. A chunk request yields a transaction whose length comes from the programmed chunk size, split into bursts of at most 16 beats. If less than one chunk is left in the buffer, that remainder goes out as single accesses. Requests that arrive while a transaction is still being issued are dropped.

Top module: `dma_buf_segmenter`

## Requirements
- R1: While reset is asserted, and after it until a start is accepted, cmd_valid, done and busy are all 0.
- R2: In memory mode (periph=0), commands begin on the clock after start is taken. Each command has beats = min(remaining, 16). cmd_burst is 1 when beats > 1 and 0 when beats = 1.
- R3: The first command of a buffer carries start_addr. After each accepted command, the next address is the previous address plus beats × BEAT_BYTES (4 by default).
- R4: No command ever has a beat count of 0 or more than MAX_BURST (16).
- R5: In peripheral mode (periph=1), no command is issued while the block waits for a request. A req_single pulse produces exactly one single access (beats=1, cmd_burst=0).
- R6: A req_chunk pulse in peripheral mode opens a transaction of chunk_len beats, issued as bursts of min(left in transaction, 16). A chunk_len of 0 is treated as 1. When req_chunk and req_single are high in the same cycle, the chunk request wins.
- R7: If a chunk request arrives while fewer beats than the effective chunk size remain in the buffer, the remaining beats are issued as single accesses, one beat each.
- R8: Requests are ignored while a transaction is in flight, including in the cycle its last command is accepted. They are also ignored in memory mode. After the last command of a peripheral transaction, no command appears until a new request is given.
- R9: While cmd_valid is 1 and cmd_ready is 0, the command (address, beats, burst flag) stays unchanged.
- R10: done is a one-cycle pulse in the cycle after the last command is accepted. busy is 1 from the cycle after start through the done cycle. A zero-length buffer gives done in the cycle after start with no command. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept a new buffer (only while idle) |
| start_addr | input | ADDR_W | Byte address of the first beat |
| buf_len | input | LEN_W | Buffer length in beats |
| periph | input | 1 | 1 = peripheral side, 0 = memory side |
| chunk_len | input | CHUNK_W | Programmed chunk size in beats |
| req_single | input | 1 | Peripheral request for a single transaction |
| req_chunk | input | 1 | Peripheral request for a chunk transaction |
| cmd_ready | input | 1 | Master accepts the current command |
| cmd_valid | output | 1 | A command is offered |
| cmd_addr | output | ADDR_W | Command start address |
| cmd_beats | output | BEAT_W | Command beat count |
| cmd_burst | output | 1 | 1 = incrementing burst, 0 = single access |
| busy | output | 1 | A buffer is being segmented |
| done | output | 1 | One-cycle pulse at end of buffer |

## Verification
Two events can land in the same cycle: a peripheral request, and the acceptance of the last command of a transaction. The bench drives this on purpose by raising both request lines in every cycle where it also holds cmd_ready high, the final-acceptance cycle among them. It then checks that cmd_valid stays low until the bench gives a fresh request. Start pulses that overlap an active buffer, and stall cycles where ready is low, are mixed into the same sweeps. Every command is compared with a model that computes the expected address, beat count and burst flag arithmetically.

// File: rtl/dmaseg_pkg.sv
package dmaseg_pkg;

  typedef enum logic [1:0] {
    SEG_IDLE   = 2'd0,
    SEG_WAIT   = 2'd1,
    SEG_ISSUE  = 2'd2,
    SEG_FINISH = 2'd3
  } seg_state_e;

endpackage

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import dmaseg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       len_zero,
  input  logic       periph,
  input  logic       any_req,
  input  logic       fire,
  input  logic       txn_last,
  input  logic       buf_last,
  output seg_state_e state,
  output logic       ld_buf,
  output logic       ld_txn_mem,
  output logic       ld_txn_req
);

  seg_state_e state_d;

  always_comb begin
    state_d = state;
    case (state)
      SEG_IDLE: begin
        if (start) begin
          if (len_zero)    state_d = SEG_FINISH;
          else if (periph) state_d = SEG_WAIT;
          else             state_d = SEG_ISSUE;
        end
      end
      SEG_WAIT: begin
        if (any_req) state_d = SEG_ISSUE;
      end
      SEG_ISSUE: begin
        if (fire && txn_last) begin
          if (buf_last) state_d = SEG_FINISH;
          else          state_d = SEG_WAIT;
        end
      end
      SEG_FINISH: state_d = SEG_IDLE;
      default:    state_d = SEG_IDLE;
    endcase
  end

  always_comb begin
    ld_buf     = (state == SEG_IDLE) && start;
    ld_txn_mem = (state == SEG_IDLE) && start && !periph && !len_zero;
    ld_txn_req = (state == SEG_WAIT) && any_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEG_IDLE;
    else        state <= state_d;
  end

endmodule

// File: rtl/seg_txn_sel.sv
module seg_txn_sel #(
  parameter int LEN_W   = 12,
  parameter int CHUNK_W = 8
) (
  input  logic [LEN_W-1:0]   buf_left,
  input  logic [CHUNK_W-1:0] chunk_len,
  input  logic               req_chunk,
  output logic [LEN_W-1:0]   txn_len,
  output logic               txn_single
);

  logic [LEN_W-1:0] eff_chunk;

  always_comb begin
    if (chunk_len == '0) eff_chunk = LEN_W'(1);
    else                 eff_chunk = LEN_W'(chunk_len);
  end

  always_comb begin
    if (req_chunk) begin
      if (buf_left >= eff_chunk) begin
        txn_len    = eff_chunk;
        txn_single = 1'b0;
      end else begin
        txn_len    = buf_left;
        txn_single = 1'b1;
      end
    end else begin
      txn_len    = LEN_W'(1);
      txn_single = 1'b1;
    end
  end

endmodule

// File: rtl/seg_beat_calc.sv
module seg_beat_calc #(
  parameter int LEN_W     = 12,
  parameter int MAX_BURST = 16,
  parameter int BEAT_W    = 5
) (
  input  logic [LEN_W-1:0]  txn_left,
  input  logic              txn_single,
  output logic [BEAT_W-1:0] beats,
  output logic              burst
);

  localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_BURST);

  always_comb begin
    if (txn_single)           beats = BEAT_W'(1);
    else if (txn_left >= CAP) beats = BEAT_W'(MAX_BURST);
    else                      beats = txn_left[BEAT_W-1:0];
    burst = (beats > BEAT_W'(1));
  end

endmodule

// File: rtl/seg_counters.sv
module seg_counters #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int BEAT_W     = 5,
  parameter int BEAT_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_buf,
  input  logic              ld_txn,
  input  logic              fire,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  buf_len,
  input  logic [LEN_W-1:0]  txn_len_in,
  input  logic              txn_single_in,
  input  logic [BEAT_W-1:0] beats,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  buf_left,
  output logic [LEN_W-1:0]  txn_left,
  output logic              txn_single
);

  logic [ADDR_W-1:0] addr_d;
  logic [LEN_W-1:0]  buf_left_d, txn_left_d;
  logic              txn_single_d;
  logic              addr_en, buf_en, txn_en;

  always_comb begin
    addr_en = ld_buf || fire;
    buf_en  = ld_buf || fire;
    txn_en  = ld_txn || fire;

    if (ld_buf) addr_d = start_addr;
    else        addr_d = addr + (ADDR_W'(beats) << BEAT_SHIFT);

    if (ld_buf) buf_left_d = buf_len;
    else        buf_left_d = buf_left - LEN_W'(beats);

    if (ld_txn) begin
      txn_left_d   = txn_len_in;
      txn_single_d = txn_single_in;
    end else begin
      txn_left_d   = txn_left - LEN_W'(beats);
      txn_single_d = txn_single;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr       <= '0;
      buf_left   <= '0;
      txn_left   <= '0;
      txn_single <= 1'b0;
    end else begin
      if (addr_en) addr     <= addr_d;
      if (buf_en)  buf_left <= buf_left_d;
      if (txn_en) begin
        txn_left   <= txn_left_d;
        txn_single <= txn_single_d;
      end
    end
  end

endmodule

// File: rtl/dma_buf_segmenter.sv
module dma_buf_segmenter
  import dmaseg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int CHUNK_W    = 8,
  parameter int MAX_BURST  = 16,
  parameter int BEAT_BYTES = 4,
  localparam int BEAT_W    = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  buf_len,
  input  logic              periph,
  input  logic [CHUNK_W-1:0] chunk_len,
  input  logic              req_single,
  input  logic              req_chunk,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BEAT_W-1:0] cmd_beats,
  output logic              cmd_burst,
  output logic              busy,
  output logic              done
);

  localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);

  seg_state_e       state;
  logic             ld_buf, ld_txn_mem, ld_txn_req, ld_txn;
  logic             fire, txn_last, buf_last, any_req, len_zero;
  logic [LEN_W-1:0] buf_left, txn_left, sel_len, txn_len_in;
  logic             sel_single, txn_single, txn_single_in;
  logic [BEAT_W-1:0] beats;
  logic             burst;

  always_comb begin
    len_zero  = (buf_len == '0);
    any_req   = req_single || req_chunk;
    cmd_valid = (state == SEG_ISSUE);
    fire      = cmd_valid && cmd_ready;
    txn_last  = (txn_left == LEN_W'(beats));
    buf_last  = (buf_left == LEN_W'(beats));
    ld_txn    = ld_txn_mem || ld_txn_req;
    if (ld_txn_mem) begin
      txn_len_in    = buf_len;
      txn_single_in = 1'b0;
    end else begin
      txn_len_in    = sel_len;
      txn_single_in = sel_single;
    end
    busy      = (state != SEG_IDLE);
    done      = (state == SEG_FINISH);
    cmd_beats = beats;
    cmd_burst = burst;
  end

  seg_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .len_zero   (len_zero),
    .periph     (periph),
    .any_req    (any_req),
    .fire       (fire),
    .txn_last   (txn_last),
    .buf_last   (buf_last),
    .state      (state),
    .ld_buf     (ld_buf),
    .ld_txn_mem (ld_txn_mem),
    .ld_txn_req (ld_txn_req)
  );

  seg_txn_sel #(
    .LEN_W   (LEN_W),
    .CHUNK_W (CHUNK_W)
  ) u_sel (
    .buf_left   (buf_left),
    .chunk_len  (chunk_len),
    .req_chunk  (req_chunk),
    .txn_len    (sel_len),
    .txn_single (sel_single)
  );

  seg_beat_calc #(
    .LEN_W     (LEN_W),
    .MAX_BURST (MAX_BURST),
    .BEAT_W    (BEAT_W)
  ) u_beat (
    .txn_left   (txn_left),
    .txn_single (txn_single),
    .beats      (beats),
    .burst      (burst)
  );

  seg_counters #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .BEAT_W     (BEAT_W),
    .BEAT_SHIFT (BEAT_SHIFT)
  ) u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .ld_buf        (ld_buf),
    .ld_txn        (ld_txn),
    .fire          (fire),
    .start_addr    (start_addr),
    .buf_len       (buf_len),
    .txn_len_in    (txn_len_in),
    .txn_single_in (txn_single_in),
    .beats         (beats),
    .addr          (cmd_addr),
    .buf_left      (buf_left),
    .txn_left      (txn_left),
    .txn_single    (txn_single)
  );

endmodule

// File: rtl/dma_buf_segmenter_chk.sv
module dma_buf_segmenter_chk #(
  parameter int ADDR_W     = 32,
  parameter int BEAT_W     = 5,
  parameter int MAX_BURST  = 16,
  parameter int BEAT_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [BEAT_W-1:0] cmd_beats,
  input logic              cmd_burst,
  input logic              busy,
  input logic              done
);

  localparam int SH = $clog2(BEAT_BYTES);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);

  p_beat_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_beats != '0) && (cmd_beats <= BEAT_W'(MAX_BURST)));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=>
      (!cmd_valid || cmd_addr == $past(cmd_addr) + (ADDR_W'($past(cmd_beats)) << SH)));

  p_hold_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_addr) && $stable(cmd_beats) && $stable(cmd_burst)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && !cmd_valid));

endmodule

bind dma_buf_segmenter dma_buf_segmenter_chk #(
  .ADDR_W     (ADDR_W),
  .BEAT_W     (BEAT_W),
  .MAX_BURST  (MAX_BURST),
  .BEAT_BYTES (BEAT_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_addr  (cmd_addr),
  .cmd_beats (cmd_beats),
  .cmd_burst (cmd_burst),
  .busy      (busy),
  .done      (done)
);

// File: tb/sim_dma_buf_segmenter.sv
module sim_dma_buf_segmenter;

  logic        clk, rst_n;
  logic        start, periph, req_single, req_chunk, cmd_ready;
  logic [31:0] start_addr;
  logic [11:0] buf_len;
  logic [7:0]  chunk_len;
  logic        cmd_valid, cmd_burst, busy, done;
  logic [31:0] cmd_addr;
  logic [4:0]  cmd_beats;

  int nvec = 0;
  int nbad = 0;
  bit finished = 0;

  dma_buf_segmenter u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .buf_len(buf_len), .periph(periph), .chunk_len(chunk_len),
    .req_single(req_single), .req_chunk(req_chunk), .cmd_ready(cmd_ready),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_beats(cmd_beats),
    .cmd_burst(cmd_burst), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  // kind: 0 chunk, 1 single, 2 alternate, 3 both lines (chunk expected)
  task automatic run_buffer(input logic [31:0] a, input int len, input bit per,
                            input int chunk, input int pat, input bit poke);
    longint madr;
    int left, txn, k, cnt, b, eff;
    bit tsingle, rdy, use_chunk;
    madr = a; left = len; txn = 0; tsingle = 0; k = 0; cnt = 0;
    @(negedge clk);
    start = 1; start_addr = a; buf_len = 12'(len); periph = per;
    chunk_len = 8'(chunk);
    @(negedge clk);
    start = 0;
    check("R10 busy after start", busy, 1);
    if (len == 0) begin
      check("R10 zero-length done", done, 1);
      check("R10 zero-length no cmd", cmd_valid, 0);
      @(negedge clk);
      check("R10 done drops", done, 0);
      return;
    end
    if (!per) begin txn = left; tsingle = 0; end
    while (left > 0) begin
      if (per && txn == 0) begin
        check("R5/R8 waits for request", cmd_valid, 0);
        @(negedge clk);
        check("R5/R8 still waiting", cmd_valid, 0);
        case (pat)
          0: use_chunk = 1;
          1: use_chunk = 0;
          2: use_chunk = (k % 2) == 0;
          default: use_chunk = 1;
        endcase
        req_chunk  = use_chunk;
        req_single = !use_chunk || (pat == 3);
        if (use_chunk) begin
          eff = (chunk == 0) ? 1 : chunk;
          if (left >= eff) begin txn = eff; tsingle = 0; end
          else begin txn = left; tsingle = 1; end
        end else begin
          txn = 1; tsingle = 1;
        end
        k++;
        @(negedge clk);
        req_chunk = 0; req_single = 0;
      end
      b = tsingle ? 1 : (txn >= 16 ? 16 : txn);
      check("R2/R5/R6/R7 cmd_valid", cmd_valid, 1);
      check("R2/R4/R6/R7 beats", cmd_beats, b);
      check("R2/R5/R7 burst flag", cmd_burst, (b > 1) ? 1 : 0);
      check("R3 address", cmd_addr, madr);
      rdy = ((cnt * 7 + len) % 3) != 0;
      cnt++;
      cmd_ready  = rdy;
      req_single = 1;           // R8: ignored while in flight
      req_chunk  = 1;
      if (poke && cnt == 1) begin
        start = 1; start_addr = ~a; buf_len = 12'd3;   // R10: ignored while busy
      end
      @(negedge clk);
      start = 0; start_addr = a; buf_len = 12'(len);
      req_single = 0; req_chunk = 0; cmd_ready = 0;
      if (rdy) begin
        madr += b * 4; left -= b; txn -= b;
      end
      if (!per) txn = left;
    end
    check("R10 done after last", done, 1);
    check("R10 busy in done cycle", busy, 1);
    check("R10 no cmd in done cycle", cmd_valid, 0);
    @(negedge clk);
    check("R10 done one cycle", done, 0);
    check("R10 idle after done", busy, 0);
  endtask

  initial begin
    rst_n = 0; start = 0; start_addr = 0; buf_len = 0; periph = 0;
    chunk_len = 0; req_single = 0; req_chunk = 0; cmd_ready = 0;
    repeat (3) @(negedge clk);
    check("R1 reset cmd_valid", cmd_valid, 0);
    check("R1 reset done", done, 0);
    check("R1 reset busy", busy, 0);
    rst_n = 1;
    req_single = 1; req_chunk = 1;
    @(negedge clk);
    req_single = 0; req_chunk = 0;
    @(negedge clk);
    check("R1 idle cmd_valid", cmd_valid, 0);
    check("R1 idle busy", busy, 0);
    // memory sweep
    for (int len = 0; len <= 40; len++)
      run_buffer(32'h1000 + 32'(len) * 32'h100, len, 1'b0, 5, 0, len == 20);
    // peripheral sweep
    for (int ci = 0; ci < 6; ci++) begin
      int ch;
      case (ci)
        0: ch = 0; 1: ch = 1; 2: ch = 4; 3: ch = 16; 4: ch = 20; default: ch = 37;
      endcase
      for (int li = 0; li < 4; li++) begin
        int ln;
        case (li) 0: ln = 1; 1: ln = 5; 2: ln = 17; default: ln = 40; endcase
        for (int p = 0; p < 4; p++)
          run_buffer(32'h8000_0000 + 32'(ci * 4096 + li * 512), ln, 1'b1, ch, p,
                     (ci == 4 && li == 3 && p == 0));
      end
    end
    summary();
  end

  initial begin
    #(200000 * 10);
    nvec++; nbad++;
    $display("FAIL watchdog actual=hung expected=complete");
    summary();
  end

endmodule